// File: doc/BRIEF.md
# Programmable-Polynomial CRC Block Checker

This block computes a 32-bit cyclic redundancy signature over a block of 32-bit data words and checks it against an expected value when the block ends. The generator polynomial can be programmed. When a polynomial is written, a hardware sequencer builds a reduced lookup table on chip, one entry per clock. After that, the engine consumes 16 data bits per cycle through a chain of small table lookups. The high half of each word is processed first, then the low half.

Software programs the block through a simple write port while the block is disabled. It sets the word count, the count reload value, the seed, the expected signature and the interrupt enables. It then sets the enable bit and streams words through a valid/ready port. When the count reaches zero, the block raises a sticky done flag and compares the final signature with the expected one. A mismatch raises a sticky compare-error flag. If the reload value is non-zero, the count is reloaded and the next block starts again from the seed. Each interrupt line is its flag gated by its own enable.

Top module: `crc_scan_top`

## Requirements
- R1: After reset, and after every polynomial write (address 1) made while disabled, `tbl_busy_o` stays high for exactly 2^LOOKUP_BITS cycles (256 by default). While it is high, `in_ready` is low. The reset polynomial is 32'h04C11DB7.
- R2: The signature is the MSB-first CRC of the words with no reflection and no final inversion. Each word's bits 31 down to 16 are consumed before bits 15 down to 0, so the result equals a bit-serial shift of bit 31 first through bit 0 last.
- R3: A word accepted on one clock edge leaves `in_ready` low for the following cycle. The result of that word appears on `result_o` one edge later.
- R4: The count (address 2) drops by one for each completed word. `in_ready` is low whenever the count is zero.
- R5: When a block completes, the count is loaded from the reload register (address 3). If the reload value is non-zero, the next block starts from the seed register and not from the previous signature. A reload of zero leaves the count at zero.
- R6: Writing the seed (address 4) while disabled presets `result_o` to that value on the next cycle.
- R7: When a block completes, `done_o` sets. `cmp_err_o` sets in the same cycle if the final signature differs from the expected value (address 5). Both flags are sticky.
- R8: Writing address 7 clears `done_o` where data bit 0 is one and clears `cmp_err_o` where data bit 1 is one. This write is accepted even while the block is enabled.
- R9: `irq_done_o` is `done_o` gated by enable bit 0 of address 6. `irq_err_o` is `cmp_err_o` gated by enable bit 1 of address 6.
- R10: Writes to addresses 1 to 6 are ignored while the enable bit (address 0, bit 0) is set.
- R11: Clearing the enable bit in the cycle after a word is accepted drops that word. The result and the count stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| in_valid | input | 1 | Data word valid |
| in_ready | output | 1 | Engine can take a word |
| in_data | input | 32 | Data word |
| result_o | output | 32 | Running CRC result |
| count_o | output | CNT_W | Words left in the current block |
| tbl_busy_o | output | 1 | Lookup table is being built |
| done_o | output | 1 | Sticky block-complete flag |
| cmp_err_o | output | 1 | Sticky signature-mismatch flag |
| irq_done_o | output | 1 | Block-complete interrupt |
| irq_err_o | output | 1 | Compare-error interrupt |

## Verification
A corrupted table entry, a wrong chaining order between the lookup stages, or halves processed in the wrong order shows up on `result_o` one edge after the second half of the first word that touches that entry. The bench's bit-serial reference catches it within that same cycle. A count or phase error shows up at once as a wrong `in_ready` or `count_o`, and by the end of a block as a misplaced done or compare-error flag. Because the reference model is compared every clock, a fault is reported in the cycle it first reaches a port, not only at the end of the block.

// File: rtl/crc_scan_pkg.sv
package crc_scan_pkg;

   localparam int SIG_W = 32;

   typedef enum logic [2:0] {
      RA_CTL    = 3'd0,
      RA_POLY   = 3'd1,
      RA_COUNT  = 3'd2,
      RA_RELOAD = 3'd3,
      RA_SEED   = 3'd4,
      RA_EXPECT = 3'd5,
      RA_IRQEN  = 3'd6,
      RA_FLAGS  = 3'd7
   } reg_addr_e;

   // One table entry: nb zero-data shift steps applied to the index placed at the top.
   function automatic logic [SIG_W-1:0] tbl_entry(input logic [SIG_W-1:0] poly,
                                                  input logic [7:0] idx,
                                                  input int nb);
      logic [SIG_W-1:0] c;
      c = SIG_W'(idx) << (SIG_W - nb);
      for (int s = 0; s < 8; s++) begin
         if (s < nb) c = c[SIG_W-1] ? ((c << 1) ^ poly) : (c << 1);
      end
      return c;
   endfunction

endpackage

// File: rtl/crc_tbl_init.sv
module crc_tbl_init
   import crc_scan_pkg::*;
#(
   parameter int LOOKUP_BITS = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic [SIG_W-1:0]       poly,
   output logic                   busy,
   output logic                   wr_en,
   output logic [LOOKUP_BITS-1:0] wr_idx,
   output logic [SIG_W-1:0]       wr_val
);

   localparam int IW = LOOKUP_BITS;
   localparam int N  = 1 << LOOKUP_BITS;

   logic [IW-1:0] idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
         busy  <= 1'b1;
      end else if (start) begin
         idx_q <= '0;
         busy  <= 1'b1;
      end else if (busy) begin
         idx_q <= idx_q + 1'b1;
         if (idx_q == IW'(N - 1)) busy <= 1'b0;
      end
   end

   assign wr_en  = busy;
   assign wr_idx = idx_q;
   assign wr_val = tbl_entry(poly, 8'(idx_q), LOOKUP_BITS);

endmodule

// File: rtl/crc_step.sv
module crc_step
   import crc_scan_pkg::*;
#(
   parameter int LOOKUP_BITS = 8
) (
   input  logic                   clk,
   input  logic                   wr_en,
   input  logic [LOOKUP_BITS-1:0] wr_idx,
   input  logic [SIG_W-1:0]       wr_val,
   input  logic [SIG_W-1:0]       base,
   input  logic [15:0]            hi,
   input  logic [SIG_W-1:0]       mid_i,
   input  logic [15:0]            lo,
   output logic [SIG_W-1:0]       mid_o,
   output logic [SIG_W-1:0]       fin_o
);

   localparam int L   = LOOKUP_BITS;
   localparam int N   = 1 << L;
   localparam int NCH = 16 / L;

   logic [SIG_W-1:0] tbl [N];

   always_ff @(posedge clk) begin
      if (wr_en) tbl[wr_idx] <= wr_val;
   end

   // Half 0 works on the high half from the base state, half 1 on the low half from the staged state.
   for (genvar h = 0; h < 2; h++) begin : g_half
      logic [SIG_W-1:0] h_in;
      logic [15:0]      h_dat;
      logic [SIG_W-1:0] h_out;
      if (h == 0) begin : g_src_hi
         assign h_in  = base;
         assign h_dat = hi;
      end else begin : g_src_lo
         assign h_in  = mid_i;
         assign h_dat = lo;
      end
      for (genvar k = 0; k < NCH; k++) begin : g_stg
         localparam int TOP = 15 - k * L;
         logic [SIG_W-1:0] c_in;
         logic [SIG_W-1:0] c_out;
         logic [L-1:0]     idx;
         if (k == 0) begin : g_head
            assign c_in = h_in;
         end else begin : g_link
            assign c_in = g_stg[k-1].c_out;
         end
         assign idx   = c_in[SIG_W-1 -: L] ^ h_dat[TOP -: L];
         assign c_out = (c_in << L) ^ tbl[idx];
      end
      assign h_out = g_stg[NCH-1].c_out;
   end

   assign mid_o = g_half[0].h_out;
   assign fin_o = g_half[1].h_out;

endmodule

// File: rtl/crc_seq.sv
module crc_seq
   import crc_scan_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             tbl_busy,
   input  logic             in_valid,
   input  logic             cnt_load,
   input  logic [CNT_W-1:0] cnt_val,
   input  logic [CNT_W-1:0] reload,
   input  logic             abort,
   input  logic [SIG_W-1:0] fin,
   input  logic [SIG_W-1:0] expect_sig,
   input  logic             clr_done,
   input  logic             clr_err,
   output logic             in_ready,
   output logic             accept,
   output logic             commit,
   output logic             last,
   output logic [CNT_W-1:0] cnt,
   output logic             done,
   output logic             err
);

   logic phase;

   assign in_ready = en & ~tbl_busy & ~phase & (cnt != '0);
   assign accept   = in_valid & in_ready;
   assign commit   = phase & en & ~abort;
   assign last     = commit & (cnt == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= 1'b0;
         cnt   <= '0;
         done  <= 1'b0;
         err   <= 1'b0;
      end else begin
         phase <= accept;
         if (cnt_load)    cnt <= cnt_val;
         else if (last)   cnt <= reload;
         else if (commit) cnt <= cnt - 1'b1;
         done <= (done & ~clr_done) | last;
         err  <= (err & ~clr_err) | (last & (fin != expect_sig));
      end
   end

endmodule

// File: rtl/crc_scan_top.sv
module crc_scan_top
   import crc_scan_pkg::*;
#(
   parameter int          LOOKUP_BITS = 8,
   parameter int          CNT_W       = 16,
   parameter logic [31:0] POLY_RESET  = 32'h04C11DB7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_we,
   input  logic [2:0]       reg_addr,
   input  logic [31:0]      reg_wdata,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [31:0]      in_data,
   output logic [31:0]      result_o,
   output logic [CNT_W-1:0] count_o,
   output logic             tbl_busy_o,
   output logic             done_o,
   output logic             cmp_err_o,
   output logic             irq_done_o,
   output logic             irq_err_o
);

   if (!(LOOKUP_BITS == 2 || LOOKUP_BITS == 4 || LOOKUP_BITS == 8)) begin : g_bad_lookup
      $error("LOOKUP_BITS must be 2, 4 or 8");
   end
   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
      $error("CNT_W must lie in 1..32");
   end

   logic             en;
   logic [SIG_W-1:0] poly_q, seed_q, expect_q, result_q, mid_q;
   logic [15:0]      lo_q;
   logic [CNT_W-1:0] reload_q;
   logic [1:0]       ie_q;
   logic             fresh_q;

   logic cfg_ok, wr_poly, wr_count, wr_seed, disable_now, clr_done, clr_err;
   logic accept, commit, last, busy, tw_en;
   logic [LOOKUP_BITS-1:0] tw_idx;
   logic [SIG_W-1:0] tw_val, base, mid_d, fin;

   assign cfg_ok      = reg_we & ~en;
   assign wr_poly     = cfg_ok & (reg_addr == RA_POLY);
   assign wr_count    = cfg_ok & (reg_addr == RA_COUNT);
   assign wr_seed     = cfg_ok & (reg_addr == RA_SEED);
   assign disable_now = reg_we & (reg_addr == RA_CTL) & ~reg_wdata[0];
   assign clr_done    = reg_we & (reg_addr == RA_FLAGS) & reg_wdata[0];
   assign clr_err     = reg_we & (reg_addr == RA_FLAGS) & reg_wdata[1];
   assign base        = fresh_q ? seed_q : result_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en       <= 1'b0;
         poly_q   <= POLY_RESET;
         seed_q   <= '0;
         expect_q <= '0;
         reload_q <= '0;
         ie_q     <= '0;
         result_q <= '0;
         mid_q    <= '0;
         lo_q     <= '0;
         fresh_q  <= 1'b0;
      end else begin
         if (reg_we && reg_addr == RA_CTL) en <= reg_wdata[0];
         if (wr_poly) poly_q <= reg_wdata;
         if (wr_seed) seed_q <= reg_wdata;
         if (cfg_ok && reg_addr == RA_EXPECT) expect_q <= reg_wdata;
         if (cfg_ok && reg_addr == RA_RELOAD) reload_q <= reg_wdata[CNT_W-1:0];
         if (cfg_ok && reg_addr == RA_IRQEN)  ie_q     <= reg_wdata[1:0];
         if (wr_seed)     result_q <= reg_wdata;
         else if (commit) result_q <= fin;
         if (wr_seed || accept)            fresh_q <= 1'b0;
         else if (last && reload_q != '0)  fresh_q <= 1'b1;
         if (accept) begin
            mid_q <= mid_d;
            lo_q  <= in_data[15:0];
         end
      end
   end

   crc_tbl_init #(.LOOKUP_BITS(LOOKUP_BITS)) u_init (
      .clk(clk), .rst_n(rst_n), .start(wr_poly), .poly(poly_q),
      .busy(busy), .wr_en(tw_en), .wr_idx(tw_idx), .wr_val(tw_val)
   );

   crc_step #(.LOOKUP_BITS(LOOKUP_BITS)) u_step (
      .clk(clk), .wr_en(tw_en), .wr_idx(tw_idx), .wr_val(tw_val),
      .base(base), .hi(in_data[31:16]), .mid_i(mid_q), .lo(lo_q),
      .mid_o(mid_d), .fin_o(fin)
   );

   crc_seq #(.CNT_W(CNT_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .en(en), .tbl_busy(busy), .in_valid(in_valid),
      .cnt_load(wr_count), .cnt_val(reg_wdata[CNT_W-1:0]), .reload(reload_q),
      .abort(disable_now), .fin(fin), .expect_sig(expect_q),
      .clr_done(clr_done), .clr_err(clr_err),
      .in_ready(in_ready), .accept(accept), .commit(commit), .last(last),
      .cnt(count_o), .done(done_o), .err(cmp_err_o)
   );

   assign result_o   = result_q;
   assign tbl_busy_o = busy;
   assign irq_done_o = done_o & ie_q[0];
   assign irq_err_o  = cmp_err_o & ie_q[1];

endmodule

// File: rtl/crc_scan_chk.sv
module crc_scan_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_we,
   input logic             en,
   input logic             in_valid,
   input logic             in_ready,
   input logic [31:0]      result_o,
   input logic [CNT_W-1:0] count_o,
   input logic             tbl_busy_o,
   input logic             done_o,
   input logic             cmp_err_o
);

   AST_BUSY_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      tbl_busy_o |-> !in_ready); // R1

   AST_WORD_TAKES_TWO: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> !in_ready); // R3

   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(reg_we) && count_o != $past(count_o)) |->
         (count_o == $past(count_o) - CNT_W'(1) || $past(count_o) == CNT_W'(1))); // R4

   AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmp_err_o) |-> done_o); // R7

   AST_IDLE_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(en) && !$past(reg_we)) |-> $stable(result_o)); // R11

endmodule

bind crc_scan_top crc_scan_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .en(en), .in_valid(in_valid),
   .in_ready(in_ready), .result_o(result_o), .count_o(count_o),
   .tbl_busy_o(tbl_busy_o), .done_o(done_o), .cmp_err_o(cmp_err_o)
);

// File: tb/tb_crc_scan_top.sv
`timescale 1ns/1ps
module tb_crc_scan_top;

   localparam int CNT_W = 16;
   localparam int NTBL  = 256;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic        in_valid = 1'b0;
   logic [31:0] in_data = '0;
   logic        in_ready;
   logic [31:0] result_o;
   logic [CNT_W-1:0] count_o;
   logic        tbl_busy_o, done_o, cmp_err_o, irq_done_o, irq_err_o;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;

   always #2 clk = ~clk;

   crc_scan_top dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .result_o(result_o), .count_o(count_o),
      .tbl_busy_o(tbl_busy_o), .done_o(done_o), .cmp_err_o(cmp_err_o),
      .irq_done_o(irq_done_o), .irq_err_o(irq_err_o)
   );

   function automatic logic [31:0] ser(input logic [31:0] poly, input logic [31:0] c,
                                       input logic [31:0] w);
      for (int b = 31; b >= 0; b--) begin
         logic fb;
         fb = c[31] ^ w[b];
         c  = c << 1;
         if (fb) c = c ^ poly;
      end
      return c;
   endfunction

   function automatic logic [31:0] blk(input logic [31:0] poly, input logic [31:0] seed,
                                       input logic [31:0] q[$]);
      logic [31:0] c;
      c = seed;
      foreach (q[i]) c = ser(poly, c, q[i]);
      return c;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Behavioural reference state
   logic        m_en, m_busy, m_phase, m_done, m_err, m_fresh;
   int          m_bcnt;
   logic [31:0] m_poly, m_seed, m_exp, m_result, m_base, m_word;
   logic [CNT_W-1:0] m_cnt, m_reload;
   logic [1:0]  m_ie;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_en = 0; m_busy = 1; m_bcnt = 0; m_phase = 0; m_done = 0; m_err = 0;
         m_fresh = 0; m_poly = 32'h04C11DB7; m_seed = 0; m_exp = 0; m_result = 0;
         m_base = 0; m_word = 0; m_cnt = 0; m_reload = 0; m_ie = 0;
      end else begin
         logic rdy, acc, dis, cfg;
         rdy = m_en && !m_busy && !m_phase && (m_cnt != 0);
         acc = in_valid && rdy;
         dis = reg_we && reg_addr == 3'd0 && !reg_wdata[0];
         cfg = reg_we && !m_en;
         if (m_busy) begin
            if (m_bcnt == NTBL - 1) m_busy = 0;
            else m_bcnt++;
         end
         if (reg_we && reg_addr == 3'd7) begin
            if (reg_wdata[0]) m_done = 0;
            if (reg_wdata[1]) m_err = 0;
         end
         if (m_phase) begin
            if (m_en && !dis) begin
               m_result = ser(m_poly, m_base, m_word);
               if (m_cnt == 1) begin
                  m_done = 1;
                  if (m_result != m_exp) m_err = 1;
                  m_cnt = m_reload;
                  if (m_reload != 0) m_fresh = 1;
               end else m_cnt = m_cnt - 1'b1;
            end
            m_phase = 0;
         end
         if (acc) begin
            m_base = m_fresh ? m_seed : m_result;
            m_word = in_data;
            m_phase = 1;
            m_fresh = 0;
         end
         if (cfg) begin
            case (reg_addr)
               3'd1: begin m_poly = reg_wdata; m_busy = 1; m_bcnt = 0; end
               3'd2: m_cnt = reg_wdata[CNT_W-1:0];
               3'd3: m_reload = reg_wdata[CNT_W-1:0];
               3'd4: begin m_seed = reg_wdata; m_result = reg_wdata; m_fresh = 0; end
               3'd5: m_exp = reg_wdata;
               3'd6: m_ie = reg_wdata[1:0];
               default: ;
            endcase
         end
         if (reg_we && reg_addr == 3'd0) m_en = reg_wdata[0];
      end
   end

   // Per-cycle comparison against the reference, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R2 result", result_o, m_result);
         chk("R4 count", 32'(count_o), 32'(m_cnt));
         chk("R3 ready", 32'(in_ready), 32'(m_en && !m_busy && !m_phase && (m_cnt != 0)));
         chk("R1 busy", 32'(tbl_busy_o), 32'(m_busy));
         chk("R7 done", 32'(done_o), 32'(m_done));
         chk("R7 err", 32'(cmp_err_o), 32'(m_err));
         chk("R9 irq_done", 32'(irq_done_o), 32'(m_done && m_ie[0]));
         chk("R9 irq_err", 32'(irq_err_o), 32'(m_err && m_ie[1]));
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         n_bad++;
         $display("FAIL R3 watchdog actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   task automatic wreg(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_idle();
      while (tbl_busy_o) @(negedge clk);
   endtask

   // Valid is held high across the whole burst, so the gap cycle is exercised.
   task automatic send_burst(input logic [31:0] q[$]);
      @(negedge clk);
      in_valid = 1'b1;
      foreach (q[i]) begin
         in_data = q[i];
         while (!in_ready) @(negedge clk);
         @(negedge clk);
      end
      in_valid = 1'b0;
   endtask

   initial begin
      logic [31:0] qa[$], qb1[$], qb2[$], qc[$];
      logic [31:0] ea, eb1, eb2, ec, keep;
      int n;
      qa  = '{32'h12345678, 32'hFFFF0000, 32'h0000FFFF, 32'hA5A5C3C3};
      qb1 = '{32'h80000001, 32'h00000000, 32'hDEADBEEF};
      qb2 = '{32'h0F0F1234, 32'h7FFFFFFE};
      qc  = '{32'hCAFEF00D};
      ea  = blk(32'h04C11DB7, 32'hFFFFFFFF, qa);
      eb1 = blk(32'h1EDC6F41, 32'h12345678, qb1);
      eb2 = blk(32'h1EDC6F41, 32'h12345678, qb2);
      ec  = blk(32'h814141AB, 32'h00000000, qc);

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk("R1 busy after reset", 32'(tbl_busy_o), 32'd1);
      chk("R1 ready low after reset", 32'(in_ready), 32'd0);
      chk("R7 done after reset", 32'(done_o), 32'd0);
      chk("R2 result after reset", result_o, 32'd0);
      n = 0;
      while (tbl_busy_o) begin @(negedge clk); n++; end
      chk("R1 init length", 32'(n), 32'(NTBL));

      // Block A: matching expected signature
      wreg(3'd2, 32'd4);
      wreg(3'd3, 32'd0);
      wreg(3'd4, 32'hFFFFFFFF);
      chk("R6 seed preset", result_o, 32'hFFFFFFFF);
      wreg(3'd5, ea);
      wreg(3'd6, 32'd3);
      wreg(3'd0, 32'd1);
      send_burst(qa);
      wait_cyc(2);
      chk("R2 block A signature", result_o, ea);
      chk("R7 block A done", 32'(done_o), 32'd1);
      chk("R7 block A no mismatch", 32'(cmp_err_o), 32'd0);
      chk("R9 block A irq_done", 32'(irq_done_o), 32'd1);
      chk("R5 zero reload count", 32'(count_o), 32'd0);
      chk("R4 ready low at zero", 32'(in_ready), 32'd0);

      // Configuration lock while enabled
      wreg(3'd2, 32'd9);
      chk("R10 count write ignored", 32'(count_o), 32'd0);
      wreg(3'd1, 32'h1EDC6F41);
      chk("R10 poly write ignored", 32'(tbl_busy_o), 32'd0);
      wreg(3'd7, 32'd1);
      chk("R8 done cleared", 32'(done_o), 32'd0);
      chk("R8 irq_done cleared", 32'(irq_done_o), 32'd0);

      // Block B: mismatching expected, auto reload, second block from seed
      wreg(3'd0, 32'd0);
      wreg(3'd1, 32'h1EDC6F41);
      chk("R1 busy after poly write", 32'(tbl_busy_o), 32'd1);
      wait_idle();
      wreg(3'd2, 32'd3);
      wreg(3'd3, 32'd2);
      wreg(3'd4, 32'h12345678);
      wreg(3'd5, 32'hDEADBEEF);
      wreg(3'd6, 32'd2);
      wreg(3'd0, 32'd1);
      send_burst(qb1);
      wait_cyc(2);
      chk("R2 block B1 signature", result_o, eb1);
      chk("R7 block B1 mismatch", 32'(cmp_err_o), 32'd1);
      chk("R9 irq_err enabled", 32'(irq_err_o), 32'd1);
      chk("R9 irq_done masked", 32'(irq_done_o), 32'd0);
      chk("R5 reload count", 32'(count_o), 32'd2);
      send_burst(qb2);
      wait_cyc(2);
      chk("R5 block B2 restarts from seed", result_o, eb2);
      chk("R5 reload again", 32'(count_o), 32'd2);

      // Abort in the second half cycle
      keep = result_o;
      @(negedge clk);
      in_valid = 1'b1; in_data = 32'h55AA55AA;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = 32'd0;
      @(negedge clk);
      reg_we = 1'b0;
      wait_cyc(1);
      chk("R11 abort keeps result", result_o, keep);
      chk("R11 abort keeps count", 32'(count_o), 32'd2);

      // Block C: new polynomial, single word, matching
      wreg(3'd7, 32'd3);
      chk("R8 err cleared", 32'(cmp_err_o), 32'd0);
      chk("R8 done cleared both", 32'(done_o), 32'd0);
      wreg(3'd1, 32'h814141AB);
      wait_idle();
      wreg(3'd2, 32'd1);
      wreg(3'd3, 32'd0);
      wreg(3'd4, 32'd0);
      wreg(3'd5, ec);
      wreg(3'd6, 32'd3);
      wreg(3'd0, 32'd1);
      send_burst(qc);
      wait_cyc(2);
      chk("R2 block C signature", result_o, ec);
      chk("R7 block C match", 32'(cmp_err_o), 32'd0);
      chk("R7 block C done", 32'(done_o), 32'd1);

      wait_cyc(4);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule